// File: doc/BRIEF.md
# Banked Dual-Mode Read Memory

This block is an on-chip random-access memory assembled from several equal banks of 512 words each. Placing banks one after another gives a total depth beyond a single bank. Each bank is also split into narrower side-by-side slices. The slices share the same address lines, and each slice stores its own part of the data word. The write port and the read port are separate. Each port has its own address, data and enable, and both share one clock.

Writes are synchronous. On a rising edge with the write enable high, the word is stored in the bank named by the upper address bits. Those bits are decoded into one enable per bank, so at most one bank stores the word.

A mode input selects the read behaviour:
- **Registered read (mode low):** the read enable is the load enable of an output register. That register captures the word already chosen by the bank multiplexer.
- **Flow-through read (mode high):** the read enable gates the addressed word straight through to the output.

Addresses past the configured depth never write anything and always read as zero.

Top module: `banked_ram`

## Requirements
- R1: A word is stored only on a rising clock edge where `wr_en` is high. When `wr_en` is low, `wr_addr` and `wr_data` change nothing.
- R2: With `async_rd` = 0 and `rd_en` = 1 at a rising edge, `rd_data` shows the word at the `rd_addr` sampled at that edge. It appears after the edge and stays until the next load.
- R3: With `async_rd` = 0 and `rd_en` = 0, `rd_data` keeps its previous value at each edge, whatever `rd_addr` does.
- R4: With `async_rd` = 1, `rd_data` combinationally equals the word at `rd_addr` while `rd_en` = 1, and is all zeros while `rd_en` = 0.
- R5: Address bits [8:0] select the word within a bank, and the bits above them select the bank. A write asserts at most one per-bank write enable.
- R6: The upper read-address bits drive the read multiplexer. Addresses that share bits [8:0] but lie in different banks return their own distinct words.
- R7: In registered mode, a read and a write to the same address at the same edge return the word stored before that write.
- R8: An address whose bits above bit 8 are not less than `N_BANKS` is ignored on write and reads as zero in both modes. `N_BANKS` must be a power of two.
- R9: Each bank stores the data word as `DATA_W/SLICE_W` slices side by side. Every bit of `wr_data` is returned unchanged.
- R10: While `rst_n` is low, and after reset until the first registered load, `rd_data` in registered mode is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and the read register |
| rst_n | input | 1 | Active-low reset of the read register |
| async_rd | input | 1 | 0 = registered read, 1 = flow-through read |
| wr_en | input | 1 | Write enable, sampled at the rising edge |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read load enable (registered) or pass enable (flow-through) |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |

## Verification
The bench fills every in-range address of a two-bank, two-slice setup using an arithmetic pattern. In that pattern, words at the same offset in the two banks differ and both nibbles vary. A wrong bank decode, a wrong multiplexer select or a lost slice therefore shows up as a mismatch.

It then reads all addresses in both modes and compares each word against a bench-side model. It also tries out-of-range writes that would alias onto bank 0 if the top address bit were dropped, and same-address read/write collisions. Held-enable patterns separate the register's hold behaviour from the zero forced on the flow-through output.

// File: rtl/ram_pkg.sv
package ram_pkg;

    typedef enum logic {
        RD_CLOCKED = 1'b0,
        RD_FLOW    = 1'b1
    } rd_mode_e;

    localparam int unsigned BANK_WORDS_DEF = 512;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ram_wr_decode.sv
module ram_wr_decode #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned OFF_W   = 9,
    parameter int unsigned N_BANKS = 4,
    parameter int unsigned BANK_W  = 2
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    output logic [N_BANKS-1:0]   bank_we,
    output logic [OFF_W-1:0]     wr_off
);
    localparam int unsigned HI_W = ADDR_W - OFF_W;
    localparam logic [HI_W:0] NB = (HI_W + 1)'(N_BANKS);

    logic [HI_W-1:0]   hi;
    logic              in_range;
    logic [BANK_W-1:0] sel;

    always_comb begin
        hi       = wr_addr[ADDR_W-1:OFF_W];
        in_range = ({1'b0, hi} < NB);
        sel      = wr_addr[OFF_W +: BANK_W];
        wr_off   = wr_addr[OFF_W-1:0];
        bank_we  = '0;
        for (int b = 0; b < int'(N_BANKS); b++) begin
            if (wr_en && in_range && (sel == BANK_W'(b))) begin
                bank_we[b] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
    parameter int unsigned OFF_W   = 9,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned SLICE_W = 4
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [OFF_W-1:0]     rd_off,
    output logic [DATA_W-1:0]    rd_word
);
    localparam int unsigned N_SLICES = DATA_W / SLICE_W;
    localparam int unsigned WORDS    = 1 << OFF_W;

    for (genvar s = 0; s < int'(N_SLICES); s++) begin : g_slice
        logic [SLICE_W-1:0] mem [WORDS];

        always_ff @(posedge clk) begin
            if (we) begin
                mem[wr_off] <= wr_data[s*SLICE_W +: SLICE_W];
            end
        end

        assign rd_word[s*SLICE_W +: SLICE_W] = mem[rd_off];
    end

endmodule

// File: rtl/ram_read_path.sv
module ram_read_path
    import ram_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned OFF_W   = 9,
    parameter int unsigned N_BANKS = 4,
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned DATA_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            async_rd,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [N_BANKS-1:0][DATA_W-1:0]  bank_words,
    output logic [DATA_W-1:0]               sel_word,
    output logic [DATA_W-1:0]               rd_data
);
    localparam int unsigned HI_W = ADDR_W - OFF_W;
    localparam logic [HI_W:0] NB = (HI_W + 1)'(N_BANKS);

    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } rd_state_t;

    rd_state_t   st_d, st_q;
    rd_mode_e    mode;
    logic        in_range;
    logic [BANK_W-1:0] sel;

    always_comb begin
        mode     = rd_mode_e'(async_rd);
        in_range = ({1'b0, rd_addr[ADDR_W-1:OFF_W]} < NB);
        sel      = rd_addr[OFF_W +: BANK_W];
        sel_word = '0;
        for (int b = 0; b < int'(N_BANKS); b++) begin
            if (in_range && (sel == BANK_W'(b))) begin
                sel_word = bank_words[b];
            end
        end

        st_d = st_q;
        if (mode == RD_CLOCKED && rd_en) begin
            st_d.dout = sel_word;
        end

        if (mode == RD_FLOW) begin
            rd_data = rd_en ? sel_word : '0;
        end else begin
            rd_data = st_q.dout;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/banked_ram.sv
module banked_ram
    import ram_pkg::*;
#(
    parameter int unsigned N_BANKS    = 4,
    parameter int unsigned BANK_WORDS = ram_pkg::BANK_WORDS_DEF,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SLICE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              async_rd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned OFF_W  = $clog2(BANK_WORDS);
    localparam int unsigned BANK_W = idx_bits(N_BANKS);

    logic [N_BANKS-1:0]             bank_we;
    logic [OFF_W-1:0]               wr_off;
    logic [N_BANKS-1:0][DATA_W-1:0] bank_words;
    logic [DATA_W-1:0]              sel_word;

    ram_wr_decode #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .N_BANKS(N_BANKS),
        .BANK_W (BANK_W)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .bank_we(bank_we),
        .wr_off (wr_off)
    );

    for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_bank
        ram_bank #(
            .OFF_W  (OFF_W),
            .DATA_W (DATA_W),
            .SLICE_W(SLICE_W)
        ) u_bank (
            .clk    (clk),
            .we     (bank_we[b]),
            .wr_off (wr_off),
            .wr_data(wr_data),
            .rd_off (rd_addr[OFF_W-1:0]),
            .rd_word(bank_words[b])
        );
    end

    ram_read_path #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .N_BANKS(N_BANKS),
        .BANK_W (BANK_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_rd  (async_rd),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .bank_words(bank_words),
        .sel_word  (sel_word),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/banked_ram_chk.sv
module banked_ram_chk #(
    parameter int unsigned N_BANKS = 4,
    parameter int unsigned OFF_W   = 9,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              async_rd,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [N_BANKS-1:0] bank_we,
    input logic [DATA_W-1:0] sel_word
);
    localparam int unsigned HI_W = ADDR_W - OFF_W;
    localparam logic [HI_W:0] NB = (HI_W + 1)'(N_BANKS);

    logic wr_oob, rd_oob;
    assign wr_oob = !({1'b0, wr_addr[ADDR_W-1:OFF_W]} < NB);
    assign rd_oob = !({1'b0, rd_addr[ADDR_W-1:OFF_W]} < NB);

    // R5: at most one bank enable in any cycle
    p_one_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R1: no bank enable without a write request
    p_we_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (bank_we == '0));

    // R8: out-of-range write reaches no bank
    p_oob_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_oob) |-> (bank_we == '0));

    // R8: out-of-range flow-through read is zero
    p_oob_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (async_rd && rd_en && rd_oob) |-> (rd_data == '0));

    // R4: flow-through output is zero when not enabled
    p_flow_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (async_rd && !rd_en) |-> (rd_data == '0));

    // R3: registered output holds when not enabled
    p_sync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!async_rd && !rd_en) && !async_rd)
            |-> $stable(rd_data));

    // R2: registered output carries the word selected at the loading edge
    p_sync_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!async_rd && rd_en) && !async_rd)
            |-> (rd_data == $past(sel_word)));

endmodule

bind banked_ram banked_ram_chk #(
    .N_BANKS(N_BANKS),
    .OFF_W  (OFF_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_rd(async_rd),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .bank_we (bank_we),
    .sel_word(sel_word)
);

// File: tb/tb_banked_ram.sv
module tb_banked_ram;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 2;
    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = NB * 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          async_rd = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_ram #(
        .N_BANKS(NB), .BANK_WORDS(512), .ADDR_W(AW), .DATA_W(DW), .SLICE_W(4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .async_rd(async_rd),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 29 + (a / 512) * 113 + 7);
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_addr = AW'(a);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic sync_read(input int a, output logic [DW-1:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
        v       = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        chk("R10 in reset", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", rd_data, '0);

        // R5 R9: fill all in-range words
        for (int a = 0; a < DEPTH; a++) begin
            do_write(a, pat(a));
            model[a] = pat(a);
        end

        // R8: out-of-range writes alias onto bank 0 offsets if decoded wrongly
        for (int k = 0; k < 64; k++) begin
            do_write(DEPTH + k * 8, 8'hA5);
        end

        // R1: write port activity with wr_en low
        @(negedge clk);
        wr_addr = AW'(5);
        wr_data = 8'h3C;
        repeat (3) @(negedge clk);

        // R2 R6 R9 R8 R1: registered sweep of every word
        for (int a = 0; a < DEPTH; a++) begin
            sync_read(a, v);
            chk("R2 R6 R9 R8 R1 registered read", v, model[a]);
        end

        // R3: hold while read enable low
        sync_read(700, v);
        @(negedge clk);
        rd_addr = AW'(3);
        repeat (3) @(negedge clk);
        chk("R3 hold", rd_data, model[700]);

        // R8: registered read of out-of-range address
        sync_read(DEPTH + 40, v);
        chk("R8 registered oob read", v, '0);

        // R4: flow-through sweep
        @(negedge clk);
        async_rd = 1'b1;
        rd_en    = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #1;
            chk("R4 flow-through read", rd_data, model[a]);
        end
        rd_addr = AW'(DEPTH + 17);
        #1;
        chk("R8 flow-through oob read", rd_data, '0);
        rd_addr = AW'(12);
        rd_en = 1'b0;
        #1;
        chk("R4 flow-through disabled", rd_data, '0);

        // R7: same-edge read and write in registered mode
        @(negedge clk);
        async_rd = 1'b0;
        rd_addr  = AW'(600);
        wr_addr  = AW'(600);
        wr_data  = 8'h5A;
        wr_en    = 1'b1;
        rd_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        chk("R7 read before write", rd_data, model[600]);
        model[600] = 8'h5A;
        sync_read(600, v);
        chk("R7 R1 new word after write", v, 8'h5A);
        sync_read(600 - 512, v);
        chk("R6 neighbour bank untouched", v, model[88]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule